// File: doc/BRIEF.md
# Supply-Monitor Reset Sequencer

This block produces the active-low system reset of a small microcontroller. An external comparator tells it whether the supply is above the reset threshold. While the monitor is active and the supply is low, reset is forced at once, with no clock needed. Once the supply is good, the block holds reset for a 100 ms stabilisation timeout, counted in clock cycles, and then releases it on a clock edge. A dip during the count starts the whole sequence again from zero.

The block keeps a power-on source flag that software reads after restart. Power-on, power-fail and software-forced resets set it. Short resets requested by other sources, such as a watchdog or an external pin, clear it. Software forces a full power-on sequence, timeout included, by writing 1 to the flag bit. Every reset restarts the core at the same address, which is presented as a constant.

Top module: `supply_reset_seq`

## Requirements
- R1: While the monitor is active (`mon_en` high, or parameter `ALWAYS_ON` nonzero) and `supply_ok` is low, `rst_n` is 0 without waiting for a clock edge, and `por_flag` is 1.
- R2: After `supply_ok` rises, `rst_n` goes to 1 right after the (TMO+2)-th rising clock edge, where TMO = CLK_HZ/10: two edges to synchronise the input, then TMO edges of timeout. If the supply drops before then, counting starts again from zero when it returns.
- R3: While the monitor is inactive, a low `supply_ok` has no effect: `rst_n` and `por_flag` keep their values.
- R4: `por_flag` reads 1 on exit from a power-on or a power-fail reset.
- R5: While `rst_n` is 1, a cycle with `reg_wr` high and `reg_wdata` bit FLAG_BIT (default bit 1) equal to 1 sets `rst_n` to 0 and `por_flag` to 1 after that edge. `rst_n` returns to 1 right after the TMO-th edge that follows. A write with that bit at 0 has no effect. Writes made while `rst_n` is 0 are ignored.
- R6: While `rst_n` is 1, any bit of `rst_req` high at an edge clears `por_flag` and drives `rst_n` to 0 for exactly SHORT_CYC (default 16) cycles. A request during such a short reset restarts its count. Requests during a power-on timeout are ignored and leave `por_flag` at 1.
- R7: If a software flag write of 1 and a reset request arrive on the same edge, the power-on sequence of R5 wins.
- R8: `rst_vec` is always 0, the common restart address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| supply_ok | input | 1 | Comparator output, high when the supply is above the threshold (asynchronous) |
| mon_en | input | 1 | Enables the supply monitor |
| rst_req | input | NREQ | Short reset requests from other sources, synchronous to clk |
| reg_wr | input | 1 | Write strobe for the flag register |
| reg_wdata | input | DW | Write data; bit FLAG_BIT forces power-on when 1 |
| por_flag | output | 1 | Power-on source flag read-back |
| rst_n | output | 1 | Active-low system reset |
| rst_vec | output | VEC_W | Restart address, constant 0 |

## Verification
The assertions assume that `rst_req`, `reg_wr` and `reg_wdata` are synchronous to `clk`, that `mon_en` changes only while `supply_ok` is high, and that the asynchronous reset formed from the supply input returns the sequencer to its power-on state. The stimulus changes every input just after a rising edge, and it toggles `mon_en` only while the supply is good. Supply drops are held for several cycles, so the only asynchronous event the block sees is a clean dip.

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
  parameter int CLK_HZ    = 2000,
  parameter int SHORT_CYC = 16,
  parameter int NREQ      = 2,
  parameter int DW        = 8,
  parameter int FLAG_BIT  = 1,
  parameter int VEC_W     = 16,
  parameter int ALWAYS_ON = 0
) (
  input  logic             clk,
  input  logic             supply_ok,
  input  logic             mon_en,
  input  logic [NREQ-1:0]  rst_req,
  input  logic             reg_wr,
  input  logic [DW-1:0]    reg_wdata,
  output logic             por_flag,
  output logic             rst_n,
  output logic [VEC_W-1:0] rst_vec
);

  localparam int TMO   = CLK_HZ / 10;
  localparam int CW_T  = $clog2(TMO + 1);
  localparam int CW_S  = $clog2(SHORT_CYC + 1);
  localparam int CW    = (CW_T > CW_S) ? CW_T : CW_S;
  localparam logic [CW-1:0] TMO_LAST = CW'(TMO - 1);
  localparam logic [CW-1:0] SHT_LAST = CW'(SHORT_CYC - 1);

  typedef enum logic [1:0] {PH_POR, PH_SHORT, PH_RUN} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [1:0]    sync;
  logic          flag_q, rst_q;

  wire mon_on = (ALWAYS_ON != 0) | mon_en;
  wire arst_n = supply_ok | ~mon_on;
  wire good   = sync[1];
  wire sw_por = reg_wr & reg_wdata[FLAG_BIT];
  wire any_rq = |rst_req;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) sync <= 2'b00;
    else         sync <= {sync[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase  <= PH_POR;
      cnt    <= '0;
      flag_q <= 1'b1;
      rst_q  <= 1'b0;
    end else begin
      case (phase)
        PH_POR: if (good) begin
          if (cnt == TMO_LAST) begin
            phase <= PH_RUN;
            rst_q <= 1'b1;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_SHORT: begin
          if (any_rq) cnt <= '0;
          else if (cnt == SHT_LAST) begin
            phase <= PH_RUN;
            rst_q <= 1'b1;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_RUN: begin
          if (sw_por) begin
            phase  <= PH_POR;
            flag_q <= 1'b1;
            rst_q  <= 1'b0;
            cnt    <= '0;
          end else if (any_rq) begin
            phase  <= PH_SHORT;
            flag_q <= 1'b0;
            rst_q  <= 1'b0;
            cnt    <= '0;
          end
        end
        default: phase <= PH_POR;
      endcase
    end
  end

  assign rst_n    = rst_q;
  assign por_flag = flag_q;
  assign rst_vec  = '0;

  logic [31:0] low_len;
  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)    low_len <= '0;
    else if (rst_q) low_len <= '0;
    else            low_len <= low_len + 1;

  p_low_while_unsynced_r1: assert property (@(posedge clk) disable iff (!arst_n)
    !good |-> !rst_n);

  p_por_release_len_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n) && por_flag |-> low_len >= TMO);

  p_sw_por_r5: assert property (@(posedge clk) disable iff (!arst_n)
    rst_n && sw_por |=> !rst_n && por_flag);

  p_req_short_r6: assert property (@(posedge clk) disable iff (!arst_n)
    rst_n && any_rq && !sw_por |=> !rst_n && !por_flag);

  p_short_len_r6: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n) && !por_flag |-> low_len >= SHORT_CYC);

  p_run_hold_r5: assert property (@(posedge clk) disable iff (!arst_n)
    rst_n && !sw_por && !any_rq |=> rst_n && $stable(por_flag));

endmodule

// File: tb/sim_supply_reset_seq.sv
`timescale 1ns/1ps
module sim_supply_reset_seq;
  localparam int CLK_HZ = 2000;
  localparam int T      = CLK_HZ / 10;
  localparam int SHORT  = 16;

  logic clk = 0;
  logic supply_ok = 0, mon_en = 1, reg_wr = 0;
  logic [1:0] rst_req = 0;
  logic [7:0] reg_wdata = 0;
  logic por_flag, rst_n;
  logic [15:0] rst_vec;

  supply_reset_seq #(.CLK_HZ(CLK_HZ), .SHORT_CYC(SHORT)) u0 (
    .clk(clk), .supply_ok(supply_ok), .mon_en(mon_en), .rst_req(rst_req),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .por_flag(por_flag),
    .rst_n(rst_n), .rst_vec(rst_vec));

  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0, cycles = 0;
  string tag = "R1";
  bit done = 0;

  // reference model: mode 0 = power-on wait, 1 = short reset, 2 = running
  int mode = 0, left = T + 2;
  bit e_flag = 1, e_rst = 0;

  function automatic void model_cold();
    mode = 0; left = T + 2; e_flag = 1; e_rst = 0;
  endfunction

  always @(posedge clk) begin
    if (mon_en && !supply_ok) model_cold();
    else begin
      case (mode)
        0: begin left--; if (left == 0) begin mode = 2; e_rst = 1; end end
        1: begin
          if (rst_req != 0) left = SHORT;
          else begin left--; if (left == 0) begin mode = 2; e_rst = 1; end end
        end
        default: begin
          if (reg_wr && reg_wdata[1]) begin mode = 0; left = T; e_flag = 1; e_rst = 0; end
          else if (rst_req != 0) begin mode = 1; left = SHORT; e_flag = 0; e_rst = 0; end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (mon_en && !supply_ok) model_cold();
    vectors++;
    if (rst_n !== e_rst || por_flag !== e_flag) begin
      miscompares++;
      $display("FAIL %s cycle %0d: rst_n=%b flag=%b expected rst_n=%b flag=%b",
               tag, cycles, rst_n, por_flag, e_rst, e_flag);
    end
    if (rst_vec !== 16'h0000) begin
      miscompares++;
      $display("FAIL R8 cycle %0d: rst_vec=%h expected 0000", cycles, rst_vec);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      miscompares++;
      $display("FAIL watchdog: %0d cycles expected under 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_pulse(logic [7:0] d, logic [1:0] rq);
    @(posedge clk); #1;
    reg_wr = 1; reg_wdata = d; rst_req = rq;
    @(posedge clk); #1;
    reg_wr = 0; reg_wdata = 0; rst_req = 0;
  endtask

  task automatic req_pulse(logic [1:0] rq);
    @(posedge clk); #1;
    rst_req = rq;
    @(posedge clk); #1;
    rst_req = 0;
  endtask

  initial begin
    tag = "R1"; wait_cyc(10);
    tag = "R2"; supply_ok = 1; wait_cyc(50);
    supply_ok = 0; wait_cyc(5);
    supply_ok = 1; wait_cyc(T + 10);
    tag = "R4"; wait_cyc(3);
    tag = "R5"; wr_pulse(8'hFD, 2'b00); wait_cyc(5);
    wr_pulse(8'h02, 2'b00); wait_cyc(T + 10);
    tag = "R6"; req_pulse(2'b01); wait_cyc(30);
    req_pulse(2'b10); wait_cyc(8);
    req_pulse(2'b11); wait_cyc(30);
    wr_pulse(8'h02, 2'b00); wait_cyc(20);
    req_pulse(2'b01); wait_cyc(T + 10);
    tag = "R7"; req_pulse(2'b01); wait_cyc(30);
    wr_pulse(8'h02, 2'b10); wait_cyc(T + 10);
    tag = "R5"; req_pulse(2'b01); wait_cyc(5);
    wr_pulse(8'h02, 2'b00); wait_cyc(30);
    tag = "R3"; mon_en = 0; wait_cyc(2);
    supply_ok = 0; wait_cyc(40);
    supply_ok = 1; wait_cyc(2);
    mon_en = 1; wait_cyc(10);
    tag = "R4"; supply_ok = 0; wait_cyc(10);
    supply_ok = 1; wait_cyc(T + 10);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule